// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block drives one clock output from one of several free-running candidate clocks. The candidates are a crystal reference, a bank of internally generated clocks, and a clock taken from an external pin. Software picks the source through a small control register. A two-bit main select chooses the source class. When the main select points at the internal bank, a sub-select chooses one internal clock, where index 0 is the fastest and the last index is the slowest. An enable bit can stop the output altogether.

A change of source never produces a short pulse on the output. The old source is gated off on its own falling edge. The new source is then passed through two falling-edge flops in its own clock domain, and only after that is it ungated. Software can read an acknowledge bit that stays high while a switch is in progress. That bit is built in the register clock domain from synchronized copies of the per-source gate state. A select written during a switch is held. The block applies it once the current switch has finished.

Top module: `clk_src_switch`

## Requirements
- R1: Out of reset the register reads 0x01 (enable bit 0 = 1, main select bits 2:1 = 00, sub-select bits 5:3 = 000, acknowledge bit 6 = 0, reserved bit 7 = 0), and the output follows the crystal clock.
- R2: The main select maps codes 00 and 10 to the crystal clock, code 01 to the internal clock chosen by the sub-select, and code 11 to the external pin clock.
- R3: With main select 01, sub-select value k routes internal clock k to the output, for every k from 0 to the last index.
- R4: Writing the enable bit as 0 holds the output low. Writing it back to 1 restarts the selected source. Neither change raises the acknowledge bit.
- R5: A write that changes the effective source leaves the acknowledge bit at 0 at the first register clock edge. The bit reads 1 from the second edge and returns to 0 once the new source is running.
- R6: A write that changes only the code and not the effective source leaves the acknowledge bit at 0 and the output unchanged. Examples are main 00 to main 10, or a new sub-select while main is not 01.
- R7: Reserved bit 7 always reads 0. The acknowledge bit ignores written values. The writable fields read back exactly what was last written.
- R8: A select written while a switch is in progress is held. After that switch completes, the output moves to the most recently written source.
- R9: At no time are two sources ungated together. The output has no high or low pulse shorter than the shortest half-period of a candidate clock.
- R10: A newly enabled source reaches the output only after two of its falling edges. Its first output rising edge therefore comes at least one and a half of its periods after the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register port clock |
| reg_rst_n | input | 1 | Active-low asynchronous reset for all flops |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| rd_data | output | REG_W | Register read value, including the acknowledge bit |
| xtal_clk | input | 1 | Crystal reference clock |
| int_clk | input | N_INT | Internal clocks, index 0 fastest |
| ext_clk | input | 1 | External pin clock |
| clk_out | output | 1 | Selected, gated output clock |

## Verification
The bench builds the block with its defaults: eight internal clocks and an 8-bit register. With those values the sub-select spans its full 3-bit range, so both the fastest and the slowest internal clocks can be selected. The acknowledge bit also lands below a reserved bit that writes of all ones can probe. Each candidate clock runs at its own distinct, non-harmonic rate. Because of that, an output that tracks the wrong source disagrees with the expected clock on a large share of samples, and aliased codes can be compared against real source changes.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    typedef enum logic [1:0] {
        MSEL_XTAL  = 2'b00,
        MSEL_INT   = 2'b01,
        MSEL_XTAL2 = 2'b10,
        MSEL_PIN   = 2'b11
    } msel_e;

    localparam int EN_BIT   = 0;
    localparam int MSEL_LSB = 1;
    localparam int SUB_LSB  = 3;
endpackage

// File: rtl/clksel_leg.sv
`timescale 1ns/1ps
module clksel_leg (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    input  logic others_busy_i,
    output logic gate_o,
    output logic busy_o,
    output logic clk_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } leg_t;

    leg_t leg_d, leg_q;

    always_comb begin
        leg_d    = leg_q;
        leg_d.s1 = req_i & ~others_busy_i;
        leg_d.s2 = leg_q.s1;
    end

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) leg_q <= '0;
        else        leg_q <= leg_d;
    end

    assign gate_o = leg_q.s2;
    assign busy_o = leg_q.s1 | leg_q.s2;
    assign clk_o  = clk_i & leg_q.s2;
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int N_INT = 8,
    parameter int REG_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wr_data,
    output logic [REG_W-1:0]             rd_data,
    input  logic [N_INT+1:0]             src_gate_i,
    input  logic [N_INT+1:0]             src_busy_i,
    output logic [N_INT+1:0]             req_o
);
    localparam int SUB_W   = $clog2(N_INT);
    localparam int NSRC    = N_INT + 2;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int ACK_BIT = SUB_LSB + SUB_W;

    typedef struct packed {
        logic             en;
        logic [1:0]       msel;
        logic [SUB_W-1:0] sub;
        logic             busy;
        logic [IDX_W-1:0] applied;
        logic [NSRC-1:0]  gate_m;
        logic [NSRC-1:0]  gate_s;
        logic [NSRC-1:0]  act_m;
        logic [NSRC-1:0]  act_s;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic [IDX_W-1:0] pick(input logic [1:0] m, input logic [SUB_W-1:0] s);
        case (msel_e'(m))
            MSEL_INT: pick = IDX_W'(s) + IDX_W'(1);
            MSEL_PIN: pick = IDX_W'(NSRC - 1);
            default:  pick = '0;
        endcase
    endfunction

    logic [IDX_W-1:0] want;
    logic [NSRC-1:0]  target;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data[REG_W-1:ACK_BIT];
    assign want   = pick(ctl_q.msel, ctl_q.sub);
    assign target = ctl_q.en ? ({{(NSRC-1){1'b0}}, 1'b1} << ctl_q.applied) : '0;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.gate_m = src_gate_i;
        ctl_d.gate_s = ctl_q.gate_m;
        ctl_d.act_m  = src_busy_i;
        ctl_d.act_s  = ctl_q.act_m;
        if (wr_en) begin
            ctl_d.en   = wr_data[EN_BIT];
            ctl_d.msel = wr_data[MSEL_LSB +: 2];
            ctl_d.sub  = wr_data[SUB_LSB +: SUB_W];
        end
        if (ctl_q.busy) begin
            if (ctl_q.gate_s == target && ctl_q.act_s == target)
                ctl_d.busy = 1'b0;
        end else if (want != ctl_q.applied) begin
            ctl_d.busy    = 1'b1;
            ctl_d.applied = want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.en <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[EN_BIT]             = ctl_q.en;
        rd_data[MSEL_LSB +: 2]      = ctl_q.msel;
        rd_data[SUB_LSB +: SUB_W]   = ctl_q.sub;
        rd_data[ACK_BIT]            = ctl_q.busy;
    end

    assign req_o = target;

    // R8: a held write must not disturb the source being switched to
    assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && $past(ctl_q.busy)) |-> $stable(ctl_q.applied));

    // R5: a source-changing write raises the acknowledge at the second edge
    assert_ack_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctl_q.busy &&
         pick(wr_data[MSEL_LSB +: 2], wr_data[SUB_LSB +: SUB_W]) != ctl_q.applied)
        |=> ##1 ctl_q.busy);

    // R6: a switch only starts when the applied source really changes
    assert_real_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.busy) |-> (ctl_q.applied != $past(ctl_q.applied)));
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch #(
    parameter int N_INT = 8,
    parameter int REG_W = 8
) (
    input  logic             reg_clk,
    input  logic             reg_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             xtal_clk,
    input  logic [N_INT-1:0] int_clk,
    input  logic             ext_clk,
    output logic             clk_out
);
    localparam int NSRC = N_INT + 2;

    logic [NSRC-1:0] src_v;
    logic [NSRC-1:0] req_v;
    logic [NSRC-1:0] gate_v;
    logic [NSRC-1:0] busy_v;
    logic [NSRC-1:0] leg_clk_v;

    assign src_v = {ext_clk, int_clk, xtal_clk};

    clksel_ctrl #(.N_INT(N_INT), .REG_W(REG_W)) i_ctrl (
        .clk        (reg_clk),
        .rst_n      (reg_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .src_gate_i (gate_v),
        .src_busy_i (busy_v),
        .req_o      (req_v)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        logic others_busy;
        assign others_busy = |(busy_v & ~({{(NSRC-1){1'b0}}, 1'b1} << i));
        clksel_leg i_leg (
            .clk_i         (src_v[i]),
            .rst_n         (reg_rst_n),
            .req_i         (req_v[i]),
            .others_busy_i (others_busy),
            .gate_o        (gate_v[i]),
            .busy_o        (busy_v[i]),
            .clk_o         (leg_clk_v[i])
        );
    end

    assign clk_out = |leg_clk_v;

    // R9: never more than one source ungated
    assert_one_gate_R9: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        $onehot0(gate_v));
endmodule

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;
    localparam int N_INT = 8;
    localparam int REG_W = 8;

    logic reg_clk = 1'b0;
    logic reg_rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic xtal_clk = 1'b0, ext_clk = 1'b0;
    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic c4 = 1'b0, c5 = 1'b0, c6 = 1'b0, c7 = 1'b0;
    logic [N_INT-1:0] int_ck;
    logic [N_INT+1:0] src_v;
    logic clk_out;

    always #2     reg_clk  = ~reg_clk;
    always #18.5  xtal_clk = ~xtal_clk;
    always #11.11 ext_clk  = ~ext_clk;
    always #3.47  c0 = ~c0;
    always #4.07  c1 = ~c1;
    always #4.63  c2 = ~c2;
    always #5.21  c3 = ~c3;
    always #5.81  c4 = ~c4;
    always #6.41  c5 = ~c5;
    always #6.94  c6 = ~c6;
    always #7.57  c7 = ~c7;
    assign int_ck = {c7, c6, c5, c4, c3, c2, c1, c0};
    assign src_v  = {ext_clk, int_ck, xtal_clk};

    clk_src_switch #(.N_INT(N_INT), .REG_W(REG_W)) i_clk_src_switch (
        .reg_clk   (reg_clk),
        .reg_rst_n (reg_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .xtal_clk  (xtal_clk),
        .int_clk   (int_ck),
        .ext_clk   (ext_clk),
        .clk_out   (clk_out)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of the writable fields, compared on every clock (R7)
    logic [7:0] m_fld = 8'h01;
    always @(posedge reg_clk) if (reg_rst_n && wr_en) m_fld <= wr_data & 8'h3F;
    always @(negedge reg_clk)
        if (reg_rst_n)
            chk((rd_data & 8'hBF) == m_fld, "R7 field readback", int'(rd_data & 8'hBF), int'(m_fld));

    // Output pulse-width monitor (R9)
    realtime last_t = 0.0;
    int glitches = 0;
    bit mon_on = 1'b0;
    always @(clk_out)
        if (mon_on) begin
            if ($realtime - last_t < 3.4) glitches++;
            last_t = $realtime;
        end

    realtime t_w;
    task automatic wr(input logic [7:0] v);
        @(negedge reg_clk);
        wr_en = 1'b1; wr_data = v;
        @(posedge reg_clk);
        t_w = $realtime;
        @(negedge reg_clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_src(input int k, input string tag);
        int bad = 0;
        int tog = 0;
        logic prev = 1'b0;
        logic e;
        for (int n = 0; n < 120; n++) begin
            @(negedge reg_clk);
            #0.7;
            e = (k < 0) ? 1'b0 : src_v[k];
            if (clk_out !== e) bad++;
            if (e != prev) tog++;
            prev = e;
        end
        if (k < 0) chk(bad == 0, tag, bad, 0);
        else       chk(bad <= 4 && tog > 10, tag, bad, 0);
    endtask

    task automatic do_switch(input logic [7:0] v, input int k, input string tag);
        bit done = 1'b0;
        wr(v);
        chk(rd_data[6] == 1'b0, {tag, " R5 ack low at first edge"}, int'(rd_data[6]), 0);
        @(negedge reg_clk);
        chk(rd_data[6] == 1'b1, {tag, " R5 ack high at second edge"}, int'(rd_data[6]), 1);
        for (int n = 0; n < 200 && !done; n++) begin
            @(negedge reg_clk);
            if (!rd_data[6]) done = 1'b1;
        end
        chk(done, {tag, " R5 ack clears"}, int'(done), 1);
        expect_src(k, tag);
    endtask

    task automatic no_switch(input logic [7:0] v, input int k, input string tag);
        int hi = 0;
        wr(v);
        for (int n = 0; n < 12; n++) begin
            @(negedge reg_clk);
            if (rd_data[6]) hi++;
        end
        chk(hi == 0, {tag, " ack stays low"}, hi, 0);
        expect_src(k, tag);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        realtime t1;
        int hi;
        int quiet;
        repeat (5) @(negedge reg_clk);
        chk(rd_data == 8'h01, "R1 reset register value", int'(rd_data), 1);
        reg_rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (30) @(negedge reg_clk);
        chk(rd_data == 8'h01, "R1 register after reset", int'(rd_data), 1);
        expect_src(0, "R1 crystal out of reset");

        do_switch(8'h03, 1, "R2 R3 main 01 sub 0");
        do_switch(8'h2B, 6, "R3 sub 5");
        do_switch(8'h07, 9, "R2 main 11 external");
        do_switch(8'h05, 0, "R2 main 10 crystal");
        no_switch(8'h01, 0, "R6 main 10 to 00");
        no_switch(8'h39, 0, "R6 sub change under main 00");
        do_switch(8'hFF, 9, "R7 all-ones write");

        // R4: enable off and back on, no acknowledge; R10 ungate latency
        wr(8'h3E);
        hi = 0;
        for (int n = 0; n < 12; n++) begin
            @(negedge reg_clk);
            if (rd_data[6]) hi++;
        end
        chk(hi == 0, "R4 disable no ack", hi, 0);
        expect_src(-1, "R4 output held low");
        wr(8'h3F);
        fork
            begin @(posedge clk_out); t1 = $realtime; end
            begin #500; t1 = -1.0; end
        join_any
        disable fork;
        chk(t1 >= 0.0 && (t1 - t_w) >= 33.0, "R10 two falling edges before ungate",
            int'(t1 - t_w), 33);
        expect_src(9, "R4 output restarted");

        // R8: second write during a switch is held and applied afterwards
        wr(8'h03);
        wr(8'h0B);
        quiet = 0;
        for (int n = 0; n < 400 && quiet < 8; n++) begin
            @(negedge reg_clk);
            if (rd_data[6]) quiet = 0; else quiet++;
        end
        chk(quiet >= 8, "R8 switches settle", quiet, 8);
        expect_src(2, "R8 latest select applied");

        do_switch(8'h3B, 8, "R3 slowest internal sub 7");
        do_switch(8'h01, 0, "R2 back to crystal");

        chk(glitches == 0, "R9 no short output pulses", glitches, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule